// File: doc/BRIEF.md
# Sixteen-by-sixteen multiply-accumulate unit with preload and rounding

The unit multiplies two 16-bit operands held in their own input registers and writes the result into a 35-bit result register. The result register is split into three parts: a 3-bit extension (bits 34..32), a 16-bit high word (bits 31..16) and a 16-bit low word (bits 15..0). The product may be written on its own, added to the register, or have the register subtracted from it. Operands are either two's complement or unsigned. An optional rounding term of 2^15 lifts the upper 19 bits to the nearest value.

All storage runs on one clock, `clk`. Three load strobes stand in for the three independent capture edges. The X operand loads on `x_ld` and the Y operand loads on `y_ld`. The four control bits load whenever either operand strobe is high. The result register updates on `p_ld`.

Each result part can be preloaded from outside. The low word's preload data arrives on the same lines as the Y operand. Each part has an active-low output enable. The pads are modelled as an output value, an output-enable flag and, where the part can be preloaded, an input.

Top module: `mac16_top`

## Requirements
- R1: The X register takes `x_in` only on a clock edge with `x_ld`=1. The Y register takes `y_lsp_in` only on a clock edge with `y_ld`=1. Otherwise each register keeps its value.
- R2: The control bits (`acc`, `sub`, `tc`, `rnd`) are captured on any clock edge where `x_ld` or `y_ld` is 1. On other edges, changes on those inputs have no effect on later results.
- R3: Reset (`rst_n`=0) clears the result register to zero. The result register changes only on edges with `p_ld`=1.
- R4: With captured `acc`=0 and `prel`=0, `p_ld` writes the product alone. `sub` has no effect.
- R5: With captured `acc`=1 and `sub`=0, `p_ld` writes register + product.
- R6: With captured `acc`=1 and `sub`=1, `p_ld` writes product − register.
- R7: With captured `tc`=1 both operands are two's complement and the 32-bit product is sign-extended to 35 bits. With `tc`=0 both are unsigned and the product is zero-extended.
- R8: With captured `rnd`=1, 2^15 (bit 15 set) is added to the result being written. With `rnd`=0 nothing is added.
- R9: Results wrap modulo 2^35 with no indication.
- R10: On `p_ld` with `prel`=1 no arithmetic update takes place. Each part whose enable input is 1 (output disabled) loads from its lines: bits 34..32 from `xtp_in`, bits 31..16 from `msp_in`, bits 15..0 from `y_lsp_in`. A part whose enable input is 0 keeps its value.
- R11: With `prel`=0, the values on `msp_in` and `xtp_in` have no effect on the result register.
- R12: Each part's output-enable flag is 1 exactly when its active-low enable input (`oe_x_n`, `oe_m_n`, `oe_l_n`) is 0. Each part's output always carries that part of the result register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| x_ld | input | 1 | Load strobe for the X operand (also captures control) |
| y_ld | input | 1 | Load strobe for the Y operand (also captures control) |
| p_ld | input | 1 | Load strobe for the result register |
| x_in | input | 16 | X operand |
| y_lsp_in | input | 16 | Y operand, also low-word preload data |
| acc | input | 1 | Accumulate select |
| sub | input | 1 | Subtract select (used when accumulating) |
| tc | input | 1 | Two's complement operands when 1 |
| rnd | input | 1 | Add rounding term 2^15 when 1 |
| prel | input | 1 | Preload select |
| msp_in | input | 16 | High-word preload data |
| xtp_in | input | 3 | Extension preload data |
| oe_x_n | input | 1 | Active-low output enable, extension |
| oe_m_n | input | 1 | Active-low output enable, high word |
| oe_l_n | input | 1 | Active-low output enable, low word |
| xtp_out | output | 3 | Extension value (bits 34..32) |
| xtp_oe | output | 1 | Extension driver enable |
| msp_out | output | 16 | High word value (bits 31..16) |
| msp_oe | output | 1 | High word driver enable |
| lsp_out | output | 16 | Low word value (bits 15..0) |
| lsp_oe | output | 1 | Low word driver enable |

## Verification
The hardest case to reach is one where the operands and the control bits were captured on different strobes from the ones that write the result. Examples are a Y-only load that picks up a new control word, or control inputs that change while neither operand strobe is high. The bench separates these strobes cycle by cycle so that stale control and stale operands show up in the product. A second hard case is the wrap at 2^35 and a preload where only some parts load. Both are reached by preloading the register with chosen patterns and chosen enable combinations, then accumulating onto them.

// File: rtl/mac16_pkg.sv
package mac16_pkg;

  typedef struct packed {
    logic acc;
    logic sub;
    logic tc;
    logic rnd;
  } mac_ctrl_t;

  typedef enum logic [1:0] {
    OP_MUL  = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUBR = 2'd2
  } mac_op_e;

  function automatic mac_op_e decode_op(input mac_ctrl_t c);
    if (!c.acc)     return OP_MUL;
    else if (c.sub) return OP_SUBR;
    else            return OP_ADD;
  endfunction

endpackage

// File: rtl/mac16_in_regs.sv
module mac16_in_regs
  import mac16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         x_ld,
  input  logic         y_ld,
  input  logic [W-1:0] x_d,
  input  logic [W-1:0] y_d,
  input  mac_ctrl_t    ctrl_d,
  output logic [W-1:0] x_q,
  output logic [W-1:0] y_q,
  output mac_ctrl_t    ctrl_q
);

  // control is captured on either operand strobe
  logic ctrl_ld;
  assign ctrl_ld = x_ld | y_ld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
    end else if (x_ld) begin
      x_q <= x_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_q <= '0;
    end else if (y_ld) begin
      y_q <= y_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_ld) begin
      ctrl_q <= ctrl_d;
    end
  end

  a_r1_x_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !x_ld |=> $stable(x_q));
  a_r1_y_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !y_ld |=> $stable(y_q));
  a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(x_ld || y_ld) |=> $stable(ctrl_q));
  a_r2_ctrl_take: assert property (@(posedge clk) disable iff (!rst_n)
    (x_ld || y_ld) |=> (ctrl_q == $past(ctrl_d)));

endmodule

// File: rtl/mac16_arith.sv
module mac16_arith
  import mac16_pkg::*;
#(
  parameter int W  = 16,
  parameter int EW = 3,
  localparam int PW = 2*W + EW
) (
  input  logic [W-1:0]  x,
  input  logic [W-1:0]  y,
  input  mac_ctrl_t     ctrl,
  input  logic [PW-1:0] p_cur,
  output logic [PW-1:0] p_next
);

  // product widened to the full register width by the operand format
  function automatic logic [PW-1:0] widen_product(
    input logic [W-1:0] a,
    input logic [W-1:0] b,
    input logic         is_signed
  );
    logic signed [2*W-1:0] sp;
    logic        [2*W-1:0] up;
    sp = $signed(a) * $signed(b);
    up = a * b;
    if (is_signed) return {{EW{sp[2*W-1]}}, sp};
    else           return {{EW{1'b0}}, up};
  endfunction

  function automatic logic [PW-1:0] round_term(input logic en);
    return en ? (PW'(1) << (W-1)) : '0;
  endfunction

  mac_op_e       op;
  logic [PW-1:0] prod_ext;
  logic [PW-1:0] rterm;

  assign op       = decode_op(ctrl);
  assign prod_ext = widen_product(x, y, ctrl.tc);
  assign rterm    = round_term(ctrl.rnd);

  always_comb begin
    unique case (op)
      OP_ADD:  p_next = p_cur + prod_ext + rterm;
      OP_SUBR: p_next = prod_ext - p_cur + rterm;
      default: p_next = prod_ext + rterm;
    endcase
  end

endmodule

// File: rtl/mac16_out_reg.sv
module mac16_out_reg #(
  parameter int W  = 16,
  parameter int EW = 3,
  localparam int PW = 2*W + EW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          p_ld,
  input  logic          prel,
  input  logic          oe_x_n,
  input  logic          oe_m_n,
  input  logic          oe_l_n,
  input  logic [EW-1:0] pre_x,
  input  logic [W-1:0]  pre_m,
  input  logic [W-1:0]  pre_l,
  input  logic [PW-1:0] p_next,
  output logic [PW-1:0] p_q,
  output logic [EW-1:0] x_out,
  output logic          x_oe,
  output logic [W-1:0]  m_out,
  output logic          m_oe,
  output logic [W-1:0]  l_out,
  output logic          l_oe
);

  // named internal events
  logic upd_arith;
  logic pre_x_en;
  logic pre_m_en;
  logic pre_l_en;

  assign upd_arith = p_ld & ~prel;
  assign pre_x_en  = p_ld & prel & oe_x_n;
  assign pre_m_en  = p_ld & prel & oe_m_n;
  assign pre_l_en  = p_ld & prel & oe_l_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q <= '0;
    end else if (upd_arith) begin
      p_q <= p_next;
    end else begin
      if (pre_x_en) p_q[PW-1:2*W]  <= pre_x;
      if (pre_m_en) p_q[2*W-1:W]   <= pre_m;
      if (pre_l_en) p_q[W-1:0]     <= pre_l;
    end
  end

  assign x_out = p_q[PW-1:2*W];
  assign m_out = p_q[2*W-1:W];
  assign l_out = p_q[W-1:0];
  assign x_oe  = ~oe_x_n;
  assign m_oe  = ~oe_m_n;
  assign l_oe  = ~oe_l_n;

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !p_ld |=> $stable(p_q));
  a_r4_arith_update: assert property (@(posedge clk) disable iff (!rst_n)
    upd_arith |=> (p_q == $past(p_next)));
  a_r10_pre_low: assert property (@(posedge clk) disable iff (!rst_n)
    pre_l_en |=> (p_q[W-1:0] == $past(pre_l)));
  a_r10_keep_high: assert property (@(posedge clk) disable iff (!rst_n)
    (p_ld && prel && !oe_m_n) |=> $stable(p_q[2*W-1:W]));
  a_r10_pre_ext: assert property (@(posedge clk) disable iff (!rst_n)
    pre_x_en |=> (p_q[PW-1:2*W] == $past(pre_x)));

endmodule

// File: rtl/mac16_top.sv
module mac16_top
  import mac16_pkg::*;
#(
  parameter int W  = 16,
  parameter int EW = 3,
  localparam int PW = 2*W + EW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          x_ld,
  input  logic          y_ld,
  input  logic          p_ld,
  input  logic [W-1:0]  x_in,
  input  logic [W-1:0]  y_lsp_in,
  input  logic          acc,
  input  logic          sub,
  input  logic          tc,
  input  logic          rnd,
  input  logic          prel,
  input  logic [W-1:0]  msp_in,
  input  logic [EW-1:0] xtp_in,
  input  logic          oe_x_n,
  input  logic          oe_m_n,
  input  logic          oe_l_n,
  output logic [EW-1:0] xtp_out,
  output logic          xtp_oe,
  output logic [W-1:0]  msp_out,
  output logic          msp_oe,
  output logic [W-1:0]  lsp_out,
  output logic          lsp_oe
);

  mac_ctrl_t     ctrl_d;
  mac_ctrl_t     ctrl_q;
  logic [W-1:0]  x_q;
  logic [W-1:0]  y_q;
  logic [PW-1:0] p_q;
  logic [PW-1:0] p_next;

  assign ctrl_d = '{acc: acc, sub: sub, tc: tc, rnd: rnd};

  mac16_in_regs #(.W(W)) u_in (
    .clk    (clk),
    .rst_n  (rst_n),
    .x_ld   (x_ld),
    .y_ld   (y_ld),
    .x_d    (x_in),
    .y_d    (y_lsp_in),
    .ctrl_d (ctrl_d),
    .x_q    (x_q),
    .y_q    (y_q),
    .ctrl_q (ctrl_q)
  );

  mac16_arith #(.W(W), .EW(EW)) u_arith (
    .x      (x_q),
    .y      (y_q),
    .ctrl   (ctrl_q),
    .p_cur  (p_q),
    .p_next (p_next)
  );

  mac16_out_reg #(.W(W), .EW(EW)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .p_ld   (p_ld),
    .prel   (prel),
    .oe_x_n (oe_x_n),
    .oe_m_n (oe_m_n),
    .oe_l_n (oe_l_n),
    .pre_x  (xtp_in),
    .pre_m  (msp_in),
    .pre_l  (y_lsp_in),
    .p_next (p_next),
    .p_q    (p_q),
    .x_out  (xtp_out),
    .x_oe   (xtp_oe),
    .m_out  (msp_out),
    .m_oe   (msp_oe),
    .l_out  (lsp_out),
    .l_oe   (lsp_oe)
  );

endmodule

// File: tb/tb_mac16_top.sv
module tb_mac16_top;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [15:0] x;
    logic [15:0] y;
    logic        acc;
    logic        sub;
    logic        tc;
    logic        rnd;
  } vec_t;

  // walked in order; the model register carries from one vector to the next
  localparam int NV = 8;
  localparam vec_t VEC [0:NV-1] = '{
    '{16'd3,     16'd5,     1'b0, 1'b0, 1'b0, 1'b0},  // R4 plain multiply
    '{16'hFFFF,  16'hFFFF,  1'b0, 1'b1, 1'b0, 1'b0},  // R4 sub ignored, R7 unsigned
    '{16'hFFFF,  16'hFFFF,  1'b0, 1'b0, 1'b1, 1'b0},  // R7 signed -1*-1
    '{16'h8000,  16'h7FFF,  1'b1, 1'b0, 1'b1, 1'b0},  // R5 R7 signed accumulate
    '{16'd100,   16'd200,   1'b1, 1'b0, 1'b0, 1'b0},  // R5 accumulate
    '{16'd7,     16'd9,     1'b1, 1'b1, 1'b0, 1'b0},  // R6 product minus register
    '{16'h1234,  16'h0010,  1'b0, 1'b0, 1'b0, 1'b1},  // R8 rounding
    '{16'hFFFD,  16'd4,     1'b1, 1'b1, 1'b1, 1'b1}   // R6 R8 signed
  };
  localparam string VTAG [0:NV-1] = '{"R4", "R4", "R7", "R5", "R5", "R6", "R8", "R6"};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic x_ld = 0, y_ld = 0, p_ld = 0;
  logic [15:0] x_in = '0, y_lsp_in = '0, msp_in = '0;
  logic acc = 0, sub = 0, tc = 0, rnd = 0, prel = 0;
  logic [2:0] xtp_in = '0;
  logic oe_x_n = 0, oe_m_n = 0, oe_l_n = 0;
  logic [2:0]  xtp_out;
  logic        xtp_oe, msp_oe, lsp_oe;
  logic [15:0] msp_out, lsp_out;

  int checks = 0;
  int errors = 0;
  logic [34:0] model;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac16_top dut (
    .clk(clk), .rst_n(rst_n), .x_ld(x_ld), .y_ld(y_ld), .p_ld(p_ld),
    .x_in(x_in), .y_lsp_in(y_lsp_in), .acc(acc), .sub(sub), .tc(tc), .rnd(rnd),
    .prel(prel), .msp_in(msp_in), .xtp_in(xtp_in),
    .oe_x_n(oe_x_n), .oe_m_n(oe_m_n), .oe_l_n(oe_l_n),
    .xtp_out(xtp_out), .xtp_oe(xtp_oe), .msp_out(msp_out), .msp_oe(msp_oe),
    .lsp_out(lsp_out), .lsp_oe(lsp_oe)
  );

  function automatic logic [34:0] ref_mac(input logic [34:0] p, input logic [15:0] a,
                                          input logic [15:0] b, input logic ac,
                                          input logic sb, input logic sg, input logic rd);
    longint pr;
    logic [34:0] pe, r;
    if (sg) pr = longint'($signed(a)) * longint'($signed(b));
    else    pr = longint'({48'd0, a}) * longint'({48'd0, b});
    pe = pr[34:0];
    r  = rd ? 35'h0_0000_8000 : 35'd0;
    if (!ac)     return pe + r;
    else if (sb) return pe - p + r;
    else         return p + pe + r;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_p(input string tag, input logic [34:0] exp);
    check(tag, 64'({xtp_out, msp_out, lsp_out}), 64'(exp));
  endtask

  // one edge with the given strobes, returns at the following falling edge
  task automatic step(input logic xl, input logic yl, input logic pl);
    x_ld = xl; y_ld = yl; p_ld = pl;
    @(negedge clk);
    x_ld = 0; y_ld = 0; p_ld = 0;
  endtask

  task automatic do_op(input vec_t v);
    x_in = v.x; y_lsp_in = v.y; acc = v.acc; sub = v.sub; tc = v.tc; rnd = v.rnd;
    step(1, 1, 0);
    step(0, 0, 1);
    model = ref_mac(model, v.x, v.y, v.acc, v.sub, v.tc, v.rnd);
  endtask

  task automatic preload(input logic [2:0] xv, input logic [15:0] mv, input logic [15:0] lv,
                         input logic ex, input logic em, input logic el);
    prel = 1; oe_x_n = ex; oe_m_n = em; oe_l_n = el;
    xtp_in = xv; msp_in = mv; y_lsp_in = lv;
    step(0, 0, 1);
    prel = 0; oe_x_n = 0; oe_m_n = 0; oe_l_n = 0;
    if (ex) model[34:32] = xv;
    if (em) model[31:16] = mv;
    if (el) model[15:0]  = lv;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    model = '0;
    repeat (3) @(negedge clk);
    // reset state, R3 and R12
    check_p("R3 reset", 35'd0);
    check("R12 enables low", 64'({xtp_oe, msp_oe, lsp_oe}), 64'(3'b111));
    rst_n = 1;
    @(negedge clk);

    // vector table
    msp_in = 16'hAAAA; xtp_in = 3'b101;  // R11 lines busy while prel=0
    for (int i = 0; i < NV; i++) begin
      do_op(VEC[i]);
      check_p(VTAG[i], model);
    end

    // R3 no p_ld: register holds while operands change
    x_in = 16'd50; y_lsp_in = 16'd60; acc = 0;
    step(1, 1, 0);
    step(0, 0, 0);
    check_p("R3 hold", model);

    // R1: Y-only load keeps old X; X-only load keeps old Y
    do_op('{16'd3, 16'd5, 1'b0, 1'b0, 1'b0, 1'b0});
    x_in = 16'd7; y_lsp_in = 16'd6;
    step(0, 1, 0);
    step(0, 0, 1);
    check_p("R1 y only", 35'd18);
    x_in = 16'd2; y_lsp_in = 16'd99;
    step(1, 0, 0);
    step(0, 0, 1);
    check_p("R1 x only", 35'd12);

    // R2: control changes without any operand strobe are not taken
    acc = 1;
    step(0, 0, 0);
    step(0, 0, 1);
    check_p("R2 stale ctrl", 35'd12);
    // R2: a Y-only strobe captures control (acc=1 now), y unchanged value 6
    y_lsp_in = 16'd6;
    step(0, 1, 0);
    step(0, 0, 1);
    check_p("R2 y strobe ctrl", 35'd24);
    model = 35'd24;

    // R10 full preload
    preload(3'b010, 16'h1357, 16'h2468, 1, 1, 1);
    check_p("R10 full preload", {3'b010, 16'h1357, 16'h2468});
    // R10 partial preload: high word stays enabled so it keeps its value
    preload(3'b011, 16'h1111, 16'h2222, 1, 0, 1);
    check_p("R10 partial preload", {3'b011, 16'h1357, 16'h2222});

    // R9 wrap at 2^35
    preload(3'b111, 16'hFFFF, 16'hFFFF, 1, 1, 1);
    do_op('{16'd1, 16'd1, 1'b1, 1'b0, 1'b0, 1'b0});
    check_p("R9 wrap", 35'd0);

    // R11: prel=0 with different line values, accumulate result follows model only
    msp_in = 16'h5A5A; xtp_in = 3'b011;
    do_op('{16'd11, 16'd13, 1'b1, 1'b0, 1'b0, 1'b0});
    check_p("R11 lines ignored", 35'd143);

    // R12 enables are per part
    oe_l_n = 1; oe_x_n = 1;
    #1;
    check("R12 per part", 64'({xtp_oe, msp_oe, lsp_oe}), 64'(3'b010));
    check_p("R12 data still out", 35'd143);
    oe_l_n = 0; oe_x_n = 0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule